// File: doc/BRIEF.md
# Double-Width Unsigned Divider with Remainder

This unit divides a 2W-bit unsigned dividend by a W-bit unsigned divisor and returns a W-bit quotient, a W-bit remainder and an overflow flag. The dividend is formed from two operand words. The high word `op_c` supplies the upper W bits and the low word `op_a` supplies the lower W bits. The divisor `op_b` is zero-extended to 2W bits.

A caller presents the operands together with a one-cycle `start` pulse while the unit is idle. On that same clock edge a guard decides whether the quotient can fit in W bits. The quotient fits only when the high word is unsigned-less-than a nonzero divisor. If it does not fit, a saturated result is returned on the next cycle. If it fits, a restoring shift-subtract loop produces one quotient bit per cycle for W cycles, and `busy` is high during that time. In both cases `done` pulses for one cycle when the outputs become valid. The outputs then hold until the next accepted start.

Top module: `divw_unit`

## Requirements
- R1: With dividend {op_c, op_a} and divisor op_b, a normal operation yields quotient = low W bits of the floor quotient and remainder = low W bits of the modulo.
- R2: An operation is normal exactly when op_c < op_b (unsigned) and op_b != 0; a normal operation reports overflow = 0 and raises busy on the cycle after start.
- R3: Any other operation reports overflow = 1, quotient = all ones and remainder = all zeros.
- R4: For an overflowing operation, done is high in the cycle right after the edge that samples start, and busy never rises.
- R5: For a normal operation, done is high after W further edges following the edge that samples start; busy is high and done low in between.
- R6: done is high for exactly one cycle per accepted operation.
- R7: A start pulse while busy is high is ignored: the running result, its overflow flag and its completion time are unchanged.
- R8: After reset, done, busy, overflow, quotient and remainder are all 0.
- R9: While the unit is idle and start is low, quotient, remainder and overflow keep their values even when the operands change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_a | input | W | Low word of the dividend |
| op_b | input | W | Divisor |
| op_c | input | W | High word of the dividend |
| busy | output | 1 | Iteration loop running |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | W | Quotient, or all ones on overflow |
| remainder | output | W | Remainder, or zero on overflow |
| overflow | output | 1 | Quotient would not fit, or divisor zero |

## Verification
The bench builds the unit at its default W = 64. At that width the bench can compute reference results with native 128-bit arithmetic. At that width the counter also reaches its full 6-bit range, so the last-iteration decode at count 63 and the W+1-edge latency are covered exactly. Random operands are mostly constrained so that the high word is below the divisor. Directed cases cover: a zero divisor, a high word equal to or greater than the divisor, and a high word of divisor minus one with an all-ones low word, where the quotient is at its maximum.

// File: rtl/divw_pkg.sv
package divw_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } divw_state_e;

endpackage

// File: rtl/divw_precheck.sv
// Guard: a W-bit quotient exists only when the high word is below a nonzero divisor.
module divw_precheck #(
    parameter int W = 64
) (
    input  logic [W-1:0] divisor,
    input  logic [W-1:0] high_word,
    output logic         fits
);
    logic divisor_zero;

    always_comb begin
        divisor_zero = (divisor == '0);
        fits         = !divisor_zero && (high_word < divisor);
    end
endmodule

// File: rtl/divw_step.sv
// One restoring step: shift the partial remainder left by one quotient-register bit,
// subtract the divisor when it fits, shift the new quotient bit in.
module divw_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] rem_in,
    input  logic [W-1:0] quo_in,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] rem_out,
    output logic [W-1:0] quo_out
);
    logic [W:0] partial;
    logic [W:0] wide_div;
    logic       take;

    always_comb begin
        partial  = {rem_in, quo_in[W-1]};
        wide_div = {1'b0, divisor};
        take     = (partial >= wide_div);
        rem_out  = take ? W'(partial - wide_div) : partial[W-1:0];
        quo_out  = {quo_in[W-2:0], take};
    end
endmodule

// File: rtl/divw_unit.sv
module divw_unit
    import divw_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         overflow
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    typedef struct packed {
        divw_state_e   state;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dvs;
        logic          ovf;
        logic          done;
    } divw_regs_t;

    divw_regs_t cur_q, nxt_d;

    logic         fits;
    logic [W-1:0] step_rem;
    logic [W-1:0] step_quo;

    divw_precheck #(.W(W)) i_precheck (
        .divisor   (op_b),
        .high_word (op_c),
        .fits      (fits)
    );

    divw_step #(.W(W)) i_step (
        .rem_in  (cur_q.rem),
        .quo_in  (cur_q.quo),
        .divisor (cur_q.dvs),
        .rem_out (step_rem),
        .quo_out (step_quo)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        unique case (cur_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (fits) begin
                        nxt_d.state = ST_RUN;
                        nxt_d.cnt   = '0;
                        nxt_d.rem   = op_c;
                        nxt_d.quo   = op_a;
                        nxt_d.dvs   = op_b;
                        nxt_d.ovf   = 1'b0;
                    end else begin
                        nxt_d.quo   = '1;
                        nxt_d.rem   = '0;
                        nxt_d.ovf   = 1'b1;
                        nxt_d.done  = 1'b1;
                    end
                end
            end
            ST_RUN: begin
                nxt_d.rem = step_rem;
                nxt_d.quo = step_quo;
                nxt_d.cnt = CW'(cur_q.cnt + 1'b1);
                if (cur_q.cnt == LAST_STEP) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.done  = 1'b1;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, cnt: '0, rem: '0, quo: '0,
                       dvs: '0, ovf: 1'b0, done: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        busy      = (cur_q.state == ST_RUN);
        done      = cur_q.done;
        quotient  = cur_q.quo;
        remainder = cur_q.rem;
        overflow  = cur_q.ovf;
    end
endmodule

// File: rtl/divw_checker.sv
module divw_checker #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] op_b,
    input logic [W-1:0] op_c,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic [W-1:0] remainder,
    input logic         overflow
);
    logic accept_bad;
    logic accept_ok;

    always_comb begin
        accept_bad = start && !busy && ((op_b == '0) || (op_c >= op_b));
        accept_ok  = start && !busy && (op_b != '0) && (op_c < op_b);
    end

    assert_normal_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_ok |=> busy && !overflow && !done);

    assert_sat_values_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && overflow) |-> (quotient == '1) && (remainder == '0));

    assert_fast_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_bad |=> done && overflow && !busy);

    assert_busy_no_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !done);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(quotient) && $stable(remainder) && $stable(overflow));
endmodule

bind divw_unit divw_checker #(.W(W)) i_divw_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_b      (op_b),
    .op_c      (op_c),
    .busy      (busy),
    .done      (done),
    .quotient  (quotient),
    .remainder (remainder),
    .overflow  (overflow)
);

// File: tb/test_divw_unit.sv
`timescale 1ns/1ps
module test_divw_unit;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] op_a = '0, op_b = '0, op_c = '0;
    logic         busy, done, overflow;
    logic [W-1:0] quotient, remainder;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    divw_unit #(.W(W)) i_divw_unit (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .busy(busy), .done(done), .quotient(quotient),
        .remainder(remainder), .overflow(overflow)
    );

    function automatic logic exp_ovf(logic [W-1:0] b, logic [W-1:0] c);
        return !((b != '0) && (c < b));
    endfunction

    function automatic logic [W-1:0] exp_quo(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [2*W-1:0] q;
        if (exp_ovf(b, c)) return '1;
        q = {c, a} / {{W{1'b0}}, b};
        return q[W-1:0];
    endfunction

    function automatic logic [W-1:0] exp_rem(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
        logic [2*W-1:0] r;
        if (exp_ovf(b, c)) return '0;
        r = {c, a} % {{W{1'b0}}, b};
        return r[W-1:0];
    endfunction

    function automatic logic [W-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Runs one operation; poke > 0 injects a second start while busy (R7).
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] c, input int poke);
        logic         eo;
        logic [W-1:0] eq, er;
        int           n, lat;
        logic         saw_busy;
        eo = exp_ovf(b, c);
        eq = exp_quo(a, b, c);
        er = exp_rem(a, b, c);
        lat = eo ? 1 : W + 1;
        saw_busy = 1'b0;
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; start = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            start = (n == poke);
            if (n == poke) begin
                op_a = rnd64(); op_b = '0; op_c = rnd64();
            end
            if (busy) saw_busy = 1'b1;
            if (!eo && n > 1 && n < lat)
                check(busy && !done, "R5", "busy/done mid-run", {busy, done}, 2'b10);
        end while (!done && n < W + 8);
        start = 1'b0;
        check(n == lat, eo ? "R4" : (poke > 0 ? "R7" : "R5"), "latency", n, lat);
        check(quotient == eq, eo ? "R3" : (poke > 0 ? "R7" : "R1"), "quotient", quotient, eq);
        check(remainder == er, eo ? "R3" : (poke > 0 ? "R7" : "R1"), "remainder", remainder, er);
        check(overflow == eo, eo ? "R3" : "R2", "overflow", overflow, eo);
        if (eo) check(!saw_busy, "R4", "busy during overflow", saw_busy, 0);
        @(negedge clk);
        check(!done, "R6", "done width", done, 0);
        op_a = rnd64(); op_b = rnd64(); op_c = rnd64();
        repeat (2) @(negedge clk);
        check(quotient == eq && remainder == er && overflow == eo, "R9", "idle hold",
              {quotient, remainder}, {eq, er});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] a, b, c;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        check(!done && !busy && !overflow && quotient == '0 && remainder == '0,
              "R8", "reset state", {busy, done, overflow}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        run_op(rnd64(), '0, '0, 0);                     // R3 zero divisor, zero high
        run_op(rnd64(), '0, rnd64(), 0);                // R3 zero divisor
        b = rnd64() | 64'h1;
        run_op(rnd64(), b, b, 0);                       // R3 high equals divisor
        run_op(rnd64(), 64'd5, 64'd9, 0);               // R3 high above divisor
        run_op('1, b, b - 1, 0);                        // R1 maximal quotient
        run_op('1, 64'd2, 64'd1, 0);                    // R1
        run_op('1, '1, '1 - 1, 0);                      // R1 largest operands
        run_op(rnd64(), 64'd1, '0, 0);                  // R1 divide by one
        run_op(64'd7, 64'd3, 64'd0, 0);                 // R1 small
        run_op(rnd64(), b, b - 1, 5);                   // R7 start while busy
        run_op(rnd64(), 64'd10, 64'd3, W - 2);          // R7 late poke

        // Constrained random
        for (int i = 0; i < 300; i++) begin
            a = rnd64();
            b = rnd64();
            if (($urandom() % 4) == 0) b = b >> ($urandom() % 64);
            if (($urandom() % 8) == 0) c = rnd64();
            else if (b != '0) c = rnd64() % b;
            else c = '0;
            run_op(a, b, c, (($urandom() % 16) == 0) ? 1 + int'($urandom() % 60) : 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule